// File: doc/BRIEF.md
# DDR2 Self-Refresh Entry and Exit Sequencer

This block sits inside a memory controller and handles taking a DDR2-style SDRAM into self-refresh and bringing it back out. The controller asks for entry with a request pulse. The sequencer waits until the controller reports that every bank is idle. It then turns the termination enable off for a fixed guard window and issues the entry command by dropping the clock enable. While the device is in self-refresh, the sequencer tells the clocking logic that the memory clock may be stopped.

When an exit request arrives and the minimum residency has passed, the sequencer withdraws that permission. It waits until the clock has been reported stable for a run of consecutive cycles, then raises the clock enable. During the exit interval it places NOP on the command pins. Two separate ready flags tell the controller when reads and when all other commands are legal again.

After every exit, the sequencer refuses a new entry until the controller reports that one auto-refresh has been issued. An entry request that arrives during this wait is held and served afterwards. All delays are cycle counts set by parameters.

Top module: `sr_seq_top`

## Requirements
- R1: After reset the outputs show the idle state: cke high, csN/rasN/casN/weN all high (deselect), busy low, readOk and cmdOk high, clkStopOk low, and odt equal to odtWant.
- R2: An enter request made while banksIdle is low is remembered and has no effect on the pins (busy stays low, cke stays high) until banksIdle goes high. Entry then starts without a new request.
- R3: Before the entry command, odt is held low for exactly ODT_OFF_CYC cycles, with the command pins at deselect. After exit, odt stays low until readOk is high.
- R4: The entry command lasts one cycle and is encoded as csN=0, rasN=0, casN=0, weN=1 with cke=0.
- R5: After the entry command, cke stays low and clkStopOk stays high for at least CKE_MIN_CYC cycles, even when the exit request arrives at once.
- R6: clkStopOk is high only from the cycle after the entry command until the exit sequence begins. It is low during the entry command and during the clock restart wait.
- R7: On exit, cke is raised only after clkStable has been high for STABLE_CYC consecutive sampled cycles. A low cycle on clkStable restarts that count.
- R8: During the exit interval, cke is high and the command pins carry NOP (csN=0, rasN=1, casN=1, weN=1). busy stays high until both exit delays have expired and drops one cycle later.
- R9: In the exit interval, counting from the first cycle cke is high as cycle 0, readOk is first high in cycle XSRD_CYC and cmdOk is first high in cycle XSNR_CYC.
- R10: After an exit, an enter request does not start entry until a refreshDone pulse is seen. A request made before that pulse is held and starts entry on the second cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterReq | input | 1 | Request to enter self-refresh (pulse or level) |
| exitReq | input | 1 | Request to leave self-refresh (pulse or level) |
| banksIdle | input | 1 | All banks are precharged and idle |
| clkStable | input | 1 | Memory clock is running and stable |
| refreshDone | input | 1 | Pulse: the required auto-refresh after exit has been issued |
| odtWant | input | 1 | Termination enable wanted by the controller |
| cke | output | 1 | Clock enable pin |
| odt | output | 1 | On-die termination pin |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| clkStopOk | output | 1 | The memory clock may be stopped or changed |
| busy | output | 1 | Sequencer owns the command pins |
| readOk | output | 1 | Read commands are allowed |
| cmdOk | output | 1 | Non-read commands are allowed |

## Verification
Two entry paths are used: a request given while banks are still busy, which must be held, and a request held back by the refresh gate after an exit. Both must produce the same guard window and the same entry command. Two exit paths are compared. In the first, the exit request comes in the first self-refresh cycle with the clock already stable, which separates the residency minimum from the stability count. In the second, the clock is stopped and the stable signal glitches, which shows whether the stability count restarts. In each exit interval, readOk, cmdOk and odt are checked on every cycle. This tells the read delay apart from the non-read delay and shows whether termination is released too early.

// File: rtl/srSeqPkg.sv
`timescale 1ns/1ps
package srSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ODT_OFF,
    ST_ENTER,
    ST_IN_SR,
    ST_CLK_WAIT,
    ST_EXIT_WAIT,
    ST_NEED_REF
  } srState_e;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_ODT,
    LD_CKE,
    LD_CLK
  } mainLoad_e;

  // strobes from control to timer datapath
  typedef struct packed {
    mainLoad_e mainLoad;
    logic      mainDec;
    logic      exitLoad;
    logic      exitDec;
  } dpCtrl_t;

  // status from timer datapath back to control
  typedef struct packed {
    logic mainZero;
    logic mainOne;
    logic readZero;
    logic cmdZero;
  } dpStat_t;

endpackage

// File: rtl/sr_seq_timer.sv
`timescale 1ns/1ps
module sr_seq_timer
  import srSeqPkg::*;
#(
  parameter int ODT_OFF_CYC = 2,
  parameter int CKE_MIN_CYC = 3,
  parameter int STABLE_CYC  = 4,
  parameter int XSRD_CYC    = 12,
  parameter int XSNR_CYC    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t dpCtrl,
  output dpStat_t dpStat
);

  localparam int MAIN_MAX = (ODT_OFF_CYC > CKE_MIN_CYC)
                          ? ((ODT_OFF_CYC > STABLE_CYC) ? ODT_OFF_CYC : STABLE_CYC)
                          : ((CKE_MIN_CYC > STABLE_CYC) ? CKE_MIN_CYC : STABLE_CYC);
  localparam int MW = $clog2(MAIN_MAX + 1);
  localparam int EXIT_MAX = (XSRD_CYC > XSNR_CYC) ? XSRD_CYC : XSNR_CYC;
  localparam int EW = $clog2(EXIT_MAX + 1);

  localparam logic [MW-1:0] ODT_V  = MW'(ODT_OFF_CYC);
  localparam logic [MW-1:0] CKE_V  = MW'(CKE_MIN_CYC - 1);
  localparam logic [MW-1:0] STAB_V = MW'(STABLE_CYC - 1);

  logic [MW-1:0] mainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCnt <= '0;
    end else begin
      unique case (dpCtrl.mainLoad)
        LD_ODT:  mainCnt <= ODT_V;
        LD_CKE:  mainCnt <= CKE_V;
        LD_CLK:  mainCnt <= STAB_V;
        default: if (dpCtrl.mainDec && mainCnt != '0) mainCnt <= mainCnt - 1'b1;
      endcase
    end
  end

  assign dpStat.mainZero = (mainCnt == '0);
  assign dpStat.mainOne  = (mainCnt == MW'(1));

  // two post-exit delay counters: index 0 = read delay, 1 = non-read delay
  logic [1:0] exitZero;

  for (genvar gi = 0; gi < 2; gi++) begin : gExitCnt
    localparam logic [EW-1:0] INIT_V = (gi == 0) ? EW'(XSRD_CYC) : EW'(XSNR_CYC);
    logic [EW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (dpCtrl.exitLoad) begin
        cnt <= INIT_V;
      end else if (dpCtrl.exitDec && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign exitZero[gi] = (cnt == '0);

    // R9: once a delay has expired it stays expired until the next exit
    assert_ok_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!dpCtrl.exitLoad && cnt == '0) |=> (cnt == '0));
  end

  assign dpStat.readZero = exitZero[0];
  assign dpStat.cmdZero  = exitZero[1];

endmodule

// File: rtl/sr_seq_ctrl.sv
`timescale 1ns/1ps
module sr_seq_ctrl
  import srSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enterReq,
  input  logic    exitReq,
  input  logic    banksIdle,
  input  logic    clkStable,
  input  logic    refreshDone,
  input  logic    odtWant,
  input  dpStat_t dpStat,
  output dpCtrl_t dpCtrl,
  output logic    cke,
  output logic    odt,
  output logic    csN,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    clkStopOk,
  output logic    busy,
  output logic    readOk,
  output logic    cmdOk
);

  srState_e state, nextState;
  logic enterPend, exitPend;
  logic enterAny, exitAny;

  assign enterAny = enterReq || enterPend;
  assign exitAny  = exitReq || exitPend;

  always_comb begin
    nextState       = state;
    dpCtrl.mainLoad = LD_NONE;
    dpCtrl.mainDec  = 1'b0;
    dpCtrl.exitLoad = 1'b0;
    dpCtrl.exitDec  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enterAny && banksIdle) begin
          nextState       = ST_ODT_OFF;
          dpCtrl.mainLoad = LD_ODT;
        end
      end
      ST_ODT_OFF: begin
        dpCtrl.mainDec = 1'b1;
        if (dpStat.mainOne || dpStat.mainZero) nextState = ST_ENTER;
      end
      ST_ENTER: begin
        nextState       = ST_IN_SR;
        dpCtrl.mainLoad = LD_CKE;
      end
      ST_IN_SR: begin
        dpCtrl.mainDec = 1'b1;
        if (exitAny && dpStat.mainZero) begin
          nextState       = ST_CLK_WAIT;
          dpCtrl.mainLoad = LD_CLK;
        end
      end
      ST_CLK_WAIT: begin
        if (!clkStable) begin
          dpCtrl.mainLoad = LD_CLK;
        end else if (dpStat.mainZero) begin
          nextState       = ST_EXIT_WAIT;
          dpCtrl.exitLoad = 1'b1;
        end else begin
          dpCtrl.mainDec = 1'b1;
        end
      end
      ST_EXIT_WAIT: begin
        dpCtrl.exitDec = 1'b1;
        if (dpStat.readZero && dpStat.cmdZero) nextState = ST_NEED_REF;
      end
      ST_NEED_REF: begin
        if (refreshDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      enterPend <= 1'b0;
      exitPend  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && nextState == ST_ODT_OFF)
        enterPend <= 1'b0;
      else if (enterReq && (state == ST_IDLE || state == ST_EXIT_WAIT || state == ST_NEED_REF))
        enterPend <= 1'b1;
      if (state == ST_IN_SR && nextState == ST_CLK_WAIT)
        exitPend <= 1'b0;
      else if (exitReq && (state == ST_ENTER || state == ST_IN_SR))
        exitPend <= 1'b1;
    end
  end

  // pin and handshake decode
  always_comb begin
    cke       = !(state == ST_ENTER || state == ST_IN_SR || state == ST_CLK_WAIT);
    clkStopOk = (state == ST_IN_SR);
    busy      = !(state == ST_IDLE || state == ST_NEED_REF);
    {csN, rasN, casN, weN} = 4'b1111;
    if (state == ST_ENTER)     {csN, rasN, casN, weN} = 4'b0001;
    if (state == ST_EXIT_WAIT) {csN, rasN, casN, weN} = 4'b0111;
    if (!busy) begin
      readOk = 1'b1;
      cmdOk  = 1'b1;
    end else if (state == ST_EXIT_WAIT) begin
      readOk = dpStat.readZero;
      cmdOk  = dpStat.cmdZero;
    end else begin
      readOk = 1'b0;
      cmdOk  = 1'b0;
    end
    odt = odtWant && readOk;
  end

  // R4: the entry command always travels with cke low
  assert_entry_cke_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && weN) |-> !cke);

  // R3: termination already off in the cycle before the entry command
  assert_odt_guard_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && weN) |-> (!$past(odt) && !odt));

  // R5: residency counter not yet expired keeps cke low next cycle
  assert_cke_min_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IN_SR && !dpStat.mainZero) |=> !cke);

  // R6: clock may only stop while cke is low and pins deselected
  assert_clkstop_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkStopOk |-> (!cke && csN));

  // R7: cke rises only after a stable clock was seen
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> $past(clkStable));

  // R8: first exit cycle keeps the pins owned and commands blocked
  assert_exit_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (busy && !readOk && !cmdOk));

  // R10: no entry starts while refresh after exit is outstanding
  assert_refresh_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NEED_REF && !refreshDone) |=> !busy);

endmodule

// File: rtl/sr_seq_top.sv
`timescale 1ns/1ps
module sr_seq_top
  import srSeqPkg::*;
#(
  parameter int ODT_OFF_CYC = 2,
  parameter int CKE_MIN_CYC = 3,
  parameter int STABLE_CYC  = 4,
  parameter int XSRD_CYC    = 12,
  parameter int XSNR_CYC    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic enterReq,
  input  logic exitReq,
  input  logic banksIdle,
  input  logic clkStable,
  input  logic refreshDone,
  input  logic odtWant,
  output logic cke,
  output logic odt,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic clkStopOk,
  output logic busy,
  output logic readOk,
  output logic cmdOk
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  sr_seq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enterReq   (enterReq),
    .exitReq    (exitReq),
    .banksIdle  (banksIdle),
    .clkStable  (clkStable),
    .refreshDone(refreshDone),
    .odtWant    (odtWant),
    .dpStat     (dpStat),
    .dpCtrl     (dpCtrl),
    .cke        (cke),
    .odt        (odt),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .clkStopOk  (clkStopOk),
    .busy       (busy),
    .readOk     (readOk),
    .cmdOk      (cmdOk)
  );

  sr_seq_timer #(
    .ODT_OFF_CYC(ODT_OFF_CYC),
    .CKE_MIN_CYC(CKE_MIN_CYC),
    .STABLE_CYC (STABLE_CYC),
    .XSRD_CYC   (XSRD_CYC),
    .XSNR_CYC   (XSNR_CYC)
  ) uTimer (
    .clk   (clk),
    .rstN  (rstN),
    .dpCtrl(dpCtrl),
    .dpStat(dpStat)
  );

endmodule

// File: tb/tb_sr_seq_top.sv
`timescale 1ns/1ps
module tb_sr_seq_top;

  localparam int ODT_OFF_CYC = 2;
  localparam int CKE_MIN_CYC = 3;
  localparam int STABLE_CYC  = 4;
  localparam int XSRD_CYC    = 12;
  localparam int XSNR_CYC    = 8;
  localparam int EXIT_MAX    = (XSRD_CYC > XSNR_CYC) ? XSRD_CYC : XSNR_CYC;

  logic clk = 1'b0;
  logic rstN, enterReq, exitReq, banksIdle, clkStable, refreshDone, odtWant;
  logic cke, odt, csN, rasN, casN, weN, clkStopOk, busy, readOk, cmdOk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sr_seq_top #(
    .ODT_OFF_CYC(ODT_OFF_CYC),
    .CKE_MIN_CYC(CKE_MIN_CYC),
    .STABLE_CYC (STABLE_CYC),
    .XSRD_CYC   (XSRD_CYC),
    .XSNR_CYC   (XSNR_CYC)
  ) dut (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .banksIdle(banksIdle), .clkStable(clkStable), .refreshDone(refreshDone),
    .odtWant(odtWant), .cke(cke), .odt(odt), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .clkStopOk(clkStopOk), .busy(busy),
    .readOk(readOk), .cmdOk(cmdOk)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cmdPins();
    return {csN, rasN, casN, weN};
  endfunction

  // starts at the first sample of the guard window; ends at first self-refresh sample
  task automatic observeEntry();
    int n = 0;
    while (busy && cke && n < 50) begin
      check("R3 odt low in guard", odt, 0);
      check("R3 deselect in guard", cmdPins(), 4'b1111);
      n++;
      @(negedge clk);
    end
    check("R3 guard length", n, ODT_OFF_CYC);
    check("R4 entry encoding", cmdPins(), 4'b0001);
    check("R4 cke low on entry", cke, 0);
    check("R6 clkStopOk low on entry", clkStopOk, 0);
    @(negedge clk);
    check("R4 single entry cycle", cmdPins(), 4'b1111);
    check("R6 clkStopOk in self-refresh", clkStopOk, 1);
    check("R5 cke low in self-refresh", cke, 0);
  endtask

  // starts at the first sample with cke high after exit
  task automatic observeExitWait();
    int k = 0;
    while (busy && k < 100) begin
      check("R8 cke high in exit", cke, 1);
      check("R8 NOP in exit", cmdPins(), 4'b0111);
      check("R9 readOk timing", readOk, int'(k >= XSRD_CYC));
      check("R9 cmdOk timing", cmdOk, int'(k >= XSNR_CYC));
      check("R3 odt held off until readOk", odt, int'(odtWant && k >= XSRD_CYC));
      k++;
      @(negedge clk);
    end
    check("R8 busy length", k, EXIT_MAX + 1);
    check("R9 readOk after exit", readOk, 1);
    check("R9 cmdOk after exit", cmdOk, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 cke", cke, 1);
    check("R1 pins", cmdPins(), 4'b1111);
    check("R1 busy", busy, 0);
    check("R1 readOk", readOk, 1);
    check("R1 cmdOk", cmdOk, 1);
    check("R1 clkStopOk", clkStopOk, 0);
    check("R1 odt follows", odt, 1);
    odtWant = 1'b0;
    #0.1;
    check("R1 odt follows low", odt, 0);
    odtWant = 1'b1;
  endtask

  task automatic testHeldByBanks();
    banksIdle = 1'b0;
    enterReq = 1'b1;
    @(negedge clk);
    enterReq = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R2 busy low while banks busy", busy, 0);
      check("R2 cke high while banks busy", cke, 1);
    end
    banksIdle = 1'b1;
    @(negedge clk);
    check("R2 entry starts once idle", busy, 1);
    observeEntry();
  endtask

  // exit requested at once with the clock already stable
  task automatic testFastExit();
    int nStop = 0;
    int nWait = 0;
    clkStable = 1'b1;
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    nStop = 1;
    while (clkStopOk && nStop < 50) begin
      check("R5 cke low during residency", cke, 0);
      nStop++;
      @(negedge clk);
    end
    check("R5 residency length", nStop, CKE_MIN_CYC);
    while (!cke && nWait < 50) begin
      check("R6 clkStopOk low during restart", clkStopOk, 0);
      nWait++;
      @(negedge clk);
    end
    check("R7 restart length", nWait, STABLE_CYC);
    observeExitWait();
  endtask

  task automatic testRefreshGate();
    enterReq = 1'b1;
    @(negedge clk);
    enterReq = 1'b0;
    repeat (6) begin
      @(negedge clk);
      check("R10 no entry before refresh", busy, 0);
      check("R10 cke high before refresh", cke, 1);
    end
    refreshDone = 1'b1;
    @(negedge clk);
    refreshDone = 1'b0;
    check("R10 idle one cycle after refresh", busy, 0);
    @(negedge clk);
    check("R10 held request starts", busy, 1);
    observeEntry();
  endtask

  // clock stopped, exit requested later, clkStable glitches
  task automatic testSlowExit();
    int k = 0;
    clkStable = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check("R6 clkStopOk held", clkStopOk, 1);
    end
    exitReq = 1'b1;
    @(negedge clk);
    exitReq = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R6 clkStopOk low after exit request", clkStopOk, 0);
      check("R7 cke low while clock unstable", cke, 0);
    end
    clkStable = 1'b1;
    repeat (STABLE_CYC - 1) @(negedge clk);
    clkStable = 1'b0;
    @(negedge clk);
    check("R7 glitch keeps cke low", cke, 0);
    clkStable = 1'b1;
    while (!cke && k < 50) begin
      @(negedge clk);
      k++;
    end
    check("R7 count restarted after glitch", k, STABLE_CYC);
    observeExitWait();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enterReq = 1'b0; exitReq = 1'b0; banksIdle = 1'b1;
    clkStable = 1'b1; refreshDone = 1'b0; odtWant = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHeldByBanks();
    testFastExit();
    testRefreshGate();
    testSlowExit();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule